// File: doc/BRIEF.md
# Systematic Reed-Solomon (44,32) Parity Encoder

This block turns a 32-byte fuse block into a 44-byte codeword for a one-time-programmable array. Symbols are bytes of GF(2^8), built on the primitive polynomial x^8+x^4+x^3+x^2+1. Data bytes arrive one per transfer on a valid/ready input stream. Each accepted byte goes at once to the output stream, unchanged. The same byte also feeds a twelve-stage byte-wide parity register. That register has constant field multipliers on its feedback path. After the 32nd byte, the block drains the twelve parity bytes onto the output stream. It then raises a one-cycle done flag and returns to idle.

A block starts with a start pulse. The parity registers clear at that point, so back-to-back blocks do not affect each other. The control is a four-state machine:

- **Idle.** Nothing is accepted.
- **Load.** The byte stream passes through while the parity is accumulated.
- **Drain.** The parity register shifts out highest order first.
- **Finish.** Lasts one cycle and asserts done.

The transitions are:

- Idle to Load on start.
- Load to Drain when the 32nd data byte is accepted.
- Drain to Finish when the 12th parity byte is accepted.
- Finish to Idle unconditionally.

Top module: `rs44_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, in_ready, out_valid and done are all 0.
- R2: While the encoder is idle, in_ready and out_valid stay 0, whatever in_valid carries, until a start pulse is seen.
- R3: During the data phase, in_ready equals out_ready and out_valid equals in_valid. Every accepted input byte appears on out_data in the same cycle, unchanged and in arrival order, as codeword bytes 0 to 31.
- R4: In the parity phase, a byte offered while out_ready is low is held on out_data with out_valid high until it is accepted. No byte is lost or repeated.
- R5: Each block produces exactly 44 output transfers: 32 data bytes, then 12 parity bytes. in_ready stays 0 once the 32nd data byte has been accepted.
- R6: The codeword is read as a polynomial with byte 0 as the coefficient of x^43 and byte 43 as the coefficient of x^0. This polynomial evaluates to zero at alpha^i for i = 0 to 11. Here alpha = 0x02 in GF(2^8), with reduction constant 0x1D for x^8+x^4+x^3+x^2+1.
- R7: A start pulse clears the parity registers. A block of all-zero data therefore yields twelve zero parity bytes, even directly after a non-zero block.
- R8: A start pulse while a block is in progress has no effect on the stream or the codeword.
- R9: done is high for exactly one cycle, the cycle right after the last parity byte is accepted. The encoder is then idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a block when the encoder is idle |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input data byte |
| in_ready | output | 1 | Encoder accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Codeword byte (data, then parity) |
| out_ready | input | 1 | Sink accepts the output byte |
| done | output | 1 | One-cycle pulse after the last parity byte |

## Verification
The encoder is driven with several kinds of block, each separating a different class of fault:

- **All-zero block after a random block.** Shows whether the parity state really clears on start.
- **All-ones block.** Exercises every feedback multiplier at once.
- **Single non-zero byte in the first or last position.** Isolates the feedback path from the carry along the stages.
- **Random blocks under random source gaps and sink stalls.** Tell correct handshaking apart from byte loss or duplication.

Each codeword is checked by two independent means. Its twelve syndromes, computed in the bench, must all be zero. Its first 32 bytes must match the input byte for byte. The check does not reuse the encoder's division. A mid-block start pulse checks that such a pulse is ignored.

// File: rtl/rs44_pkg.sv
package rs44_pkg;

    localparam int SYM_W   = 8;
    localparam int MAX_PAR = 32;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } enc_state_e;

    // Product of two field elements, shift-and-add with modular reduction.
    function automatic sym_t gf_mul(sym_t a, sym_t b, sym_t red);
        sym_t acc;
        sym_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = {t[SYM_W-2:0], 1'b0} ^ (t[SYM_W-1] ? red : '0);
        end
        return acc;
    endfunction

    // Coefficient idx of prod_{i<npar} (x + alpha^i), alpha = 2.
    function automatic sym_t gen_coef(int npar, int idx, sym_t red);
        sym_t g [0:MAX_PAR];
        sym_t root;
        for (int k = 0; k <= MAX_PAR; k++) g[k] = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < MAX_PAR; i++) begin
            if (i < npar) begin
                for (int j = MAX_PAR; j >= 1; j--) begin
                    g[j] = g[j-1] ^ gf_mul(g[j], root, red);
                end
                g[0] = gf_mul(g[0], root, red);
                root = gf_mul(root, sym_t'(2), red);
            end
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rs44_gf_cmul.sv
module rs44_gf_cmul
    import rs44_pkg::*;
#(
    parameter sym_t COEF = 8'h01,
    parameter sym_t RED  = 8'h1D
) (
    input  sym_t x,
    output sym_t y
);

    // Constant operand: the loop collapses to a fixed XOR network.
    always_comb begin
        y = gf_mul(x, COEF, RED);
    end

endmodule

// File: rtl/rs44_parity_lfsr.sv
module rs44_parity_lfsr
    import rs44_pkg::*;
#(
    parameter int   N_PAR = 12,
    parameter sym_t RED   = 8'h1D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic absorb,
    input  logic shift,
    input  sym_t din,
    output sym_t top_sym
);

    sym_t stage [N_PAR];
    sym_t prod  [N_PAR];
    sym_t fb;

    assign fb      = din ^ stage[N_PAR-1];
    assign top_sym = stage[N_PAR-1];

    for (genvar j = 0; j < N_PAR; j++) begin : g_tap
        localparam sym_t TAP = gen_coef(N_PAR, j, RED);
        rs44_gf_cmul #(.COEF(TAP), .RED(RED)) u_mul (
            .x (fb),
            .y (prod[j])
        );
    end

    for (genvar j = 0; j < N_PAR; j++) begin : g_stage
        if (j == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage[0] <= '0;
                else if (clear)  stage[0] <= '0;
                else if (absorb) stage[0] <= prod[0];
                else if (shift)  stage[0] <= '0;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage[j] <= '0;
                else if (clear)  stage[j] <= '0;
                else if (absorb) stage[j] <= stage[j-1] ^ prod[j];
                else if (shift)  stage[j] <= stage[j-1];
            end
        end
    end

endmodule

// File: rtl/rs44_enc_fsm.sv
module rs44_enc_fsm
    import rs44_pkg::*;
#(
    parameter int N_DATA = 32,
    parameter int N_PAR  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic sel_par,
    output logic clear,
    output logic absorb,
    output logic shift,
    output logic done
);

    localparam int CNT_MAX = (N_DATA > N_PAR) ? N_DATA : N_PAR;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    enc_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             last_data;
    logic             last_par;

    assign last_data = (cnt == CNT_W'(N_DATA - 1));
    assign last_par  = (cnt == CNT_W'(N_PAR - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LOAD;
            ST_LOAD:  if (in_valid && out_ready && last_data) state_nx = ST_DRAIN;
            ST_DRAIN: if (out_ready && last_par) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (state == ST_IDLE)      cnt <= '0;
        else if (absorb)                cnt <= last_data ? '0 : cnt + 1'b1;
        else if (shift)                 cnt <= cnt + 1'b1;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        sel_par   = 1'b0;
        clear     = 1'b0;
        absorb    = 1'b0;
        shift     = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clear = start;
            end
            ST_LOAD: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                absorb    = in_valid && out_ready;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                sel_par   = 1'b1;
                shift     = out_ready;
            end
            ST_DONE: begin
                done = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rs44_encoder.sv
module rs44_encoder
    import rs44_pkg::*;
#(
    parameter int   N_DATA = 32,
    parameter int   N_PAR  = 12,
    parameter sym_t RED    = 8'h1D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready,
    output logic       done
);

    logic sel_par;
    logic clear;
    logic absorb;
    logic shift;
    sym_t par_top;

    rs44_enc_fsm #(.N_DATA(N_DATA), .N_PAR(N_PAR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .sel_par   (sel_par),
        .clear     (clear),
        .absorb    (absorb),
        .shift     (shift),
        .done      (done)
    );

    rs44_parity_lfsr #(.N_PAR(N_PAR), .RED(RED)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .absorb  (absorb),
        .shift   (shift),
        .din     (in_data),
        .top_sym (par_top)
    );

    assign out_data = sel_par ? par_top : in_data;

endmodule

// File: rtl/rs44_encoder_chk.sv
module rs44_encoder_chk #(
    parameter int N_DATA = 32,
    parameter int N_PAR  = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       done
);

    localparam int TOTAL = N_DATA + N_PAR;
    localparam int OW    = $clog2(TOTAL + 1);

    logic          busy;
    logic [OW-1:0] ocnt;
    logic          last_q;
    logic          ofire;

    assign ofire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            ocnt   <= '0;
            last_q <= 1'b0;
        end else begin
            last_q <= busy && ofire && (ocnt == OW'(TOTAL - 1));
            if (!busy && !done && start) begin
                busy <= 1'b1;
                ocnt <= '0;
            end else if (busy && ofire) begin
                ocnt <= ocnt + 1'b1;
                if (ocnt == OW'(TOTAL - 1)) busy <= 1'b0;
            end
        end
    end

    // R2: no traffic outside a block
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid));

    // R3: accepted input appears unchanged on the output
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_data == in_data));

    // R3: input readiness follows the sink
    a_r3_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);

    // R4: stalled parity byte holds
    a_r4_hold_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ocnt >= OW'(N_DATA) && out_valid && !out_ready)
        |=> (out_valid && $stable(out_data)));

    // R5: no intake past the data phase
    a_r5_intake_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (ocnt < OW'(N_DATA)));

    // R9: done exactly after last accepted parity byte
    a_r9_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        done == last_q);

    // R9: single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind rs44_encoder rs44_encoder_chk #(.N_DATA(N_DATA), .N_PAR(N_PAR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .done      (done)
);

// File: tb/sim_rs44_encoder.sv
module sim_rs44_encoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready;
    logic       done;

    always #10 clk = ~clk;

    rs44_encoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .done      (done)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [7:0] tx [32];
    logic [7:0] rx [44];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Field multiply, MSB-first Horner form, x^8+x^4+x^3+x^2+1
    function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1D : 8'h00);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic int bad_syndromes();
        logic [7:0] pt = 8'h01;
        int bad = 0;
        for (int i = 0; i < 12; i++) begin
            logic [7:0] s = 8'h00;
            for (int k = 0; k < 44; k++) s = tb_mul(s, pt) ^ rx[k];
            if (s != 8'h00) bad++;
            pt = tb_mul(pt, 8'h02);
        end
        return bad;
    endfunction

    task automatic run_block(input int gap_pct, input int stall_pct,
                             input bit poke_start, input string tag);
        int ii = 0;
        int oo = 0;
        int cyc = 0;
        int done_bad = 0;
        int mism = 0;
        bit want_done = 0;
        bit acc_in = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            if (cyc != 0) @(negedge clk);
            if (done !== want_done) done_bad++;
            if (want_done) break;
            if (acc_in) in_valid = 1'b0;
            acc_in = 0;
            if (!in_valid && ii < 32 && $urandom_range(99) >= gap_pct) begin
                in_valid = 1'b1;
                in_data  = tx[ii];
            end
            out_ready = ($urandom_range(99) >= stall_pct);
            start = poke_start && (cyc == 10 || cyc == 60);
            #1;
            if (in_valid && in_ready) begin
                ii++;
                acc_in = 1;
            end
            if (out_valid && out_ready) begin
                if (oo < 44) rx[oo] = out_data;
                oo++;
                want_done = (oo == 44);
            end
            cyc++;
            if (cyc > 5000) break;
        end
        start = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        for (int k = 0; k < 32; k++) if (rx[k] != tx[k]) mism++;
        chk(mism == 0, "R3", {tag, " data passthrough mismatches"}, mism, 0);
        chk(oo == 44 && ii == 32, "R5", {tag, " output byte count"}, oo, 44);
        chk(bad_syndromes() == 0, "R6", {tag, " nonzero syndromes"}, bad_syndromes(), 0);
        chk(done_bad == 0, "R9", {tag, " done pulse timing errors"}, done_bad, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        start = 1'b0;
        in_valid = 1'b0;
        in_data = 8'h00;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 0, "R1", "in_ready in reset", in_ready, 0);
        chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        chk(done == 0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        // R2: idle ignores offered traffic
        in_valid = 1'b1;
        in_data = 8'hA5;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 0, "R2", "in_ready while idle", in_ready, 0);
        chk(out_valid == 0, "R2", "out_valid while idle", out_valid, 0);
        in_valid = 1'b0;
        out_ready = 1'b0;

        // random block, free flowing
        for (int k = 0; k < 32; k++) tx[k] = 8'($urandom);
        run_block(0, 0, 0, "rand_free");

        // R7: zero block right after a random block gives zero parity
        for (int k = 0; k < 32; k++) tx[k] = 8'h00;
        run_block(0, 0, 0, "zeros");
        begin
            int nz = 0;
            for (int k = 32; k < 44; k++) if (rx[k] != 8'h00) nz++;
            chk(nz == 0, "R7", "nonzero parity bytes after clear", nz, 0);
        end

        for (int k = 0; k < 32; k++) tx[k] = 8'hFF;
        run_block(10, 10, 0, "ones");

        for (int k = 0; k < 32; k++) tx[k] = 8'h00;
        tx[31] = 8'h01;
        run_block(0, 30, 0, "impulse_last");

        for (int k = 0; k < 32; k++) tx[k] = 8'h00;
        tx[0] = 8'h80;
        run_block(30, 0, 0, "impulse_first");

        // R4: heavy stalls and gaps
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k < 32; k++) tx[k] = 8'($urandom);
            run_block(r * 10, 60 - r * 10, 0, "rand_stall_R4");
        end

        // R8: start pulses during a block are ignored
        for (int k = 0; k < 32; k++) tx[k] = 8'($urandom);
        run_block(20, 20, 1, "start_poke_R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule